// File: doc/BRIEF.md
# Reset and Start-up Sequencer

This block decides when a microcontroller core may leave reset. It watches four sources of trouble: loss of power (a digital power-good flag), a supply that sits below the brown-out threshold (a digital comparator flag), an external active-low master-clear pin, and a wake-up from sleep. It chains two timers before it releases the core. The power-up timer counts ticks of a free-running internal RC tick. The oscillator start-up timer counts cycles of the oscillator clock and runs only in crystal modes. A glitch filter, also clocked by the RC tick, keeps short supply dips from causing a reset.

Two sticky status flags record the cause of the last reset. The power-on flag is cleared by power loss and the brown-out flag is cleared by a brown-out. Only software sets them again, through a small write port. Reading both flags after a reset tells power-on, brown-out and master-clear resets apart. The control logic runs on the `clk` domain, where `rc_tick` is a one-cycle enable. The oscillator count runs on `osc_clk` and its result is brought back through a two-flop synchronizer.

The sequencer is a state machine with five states:
- `ST_START` is entered on power-up. It goes to `ST_PWRT` when the power-up delay applies, else to `ST_OST` in a crystal mode, else to `ST_RUN`.
- `ST_PWRT` counts the delay. When the delay is done it goes to `ST_OST` (crystal mode and still on the power-on path) or to `ST_RUN`. A low-supply sample with brown-out detection enabled sends it to `ST_BROWN`.
- `ST_OST` goes to `ST_RUN` once a fresh start-up count completes.
- `ST_RUN` goes to `ST_OST` on a wake strobe in a crystal mode.
- `ST_BROWN` holds while the supply is low and goes to `ST_PWRT` when it recovers.
- A filtered brown-out trip moves any state to `ST_BROWN`.

Top module: `rstseq_top`

## Requirements
- R1: While `pwr_good` is low, `core_rst_n` is 0, `stat_por` is 0 and `stat_bor` holds the parameter `BOR_FLAG_INIT`. `stat_por` stays 0 after power-up until software writes it.
- R2: When the power-up delay applies, `core_rst_n` stays 0 for `PWRT_TICKS` rising `rc_tick` pulses after power-up before release. When the delay does not apply, no delay is inserted.
- R3: Oscillator modes are encoded `cfg_osc_mode` 0 (LP), 1 (XT), 2 (HS) and 3 (RC). On the power-on path in modes 0–2, release also waits for `OST_CYCLES` cycles of `osc_clk` after the power-up delay. In mode 3 the start-up count is skipped.
- R4: With `cfg_bor_en`=1, a brown-out is taken only when `supply_low` stays high across `BOR_TICKS` consecutive `rc_tick` pulses. A shorter dip leaves `core_rst_n` at 1.
- R5: After a brown-out, `core_rst_n` stays 0 while `supply_low` is 1. After recovery, release follows a fresh power-up delay with no start-up count, in every oscillator mode.
- R6: A `supply_low` sample of 1 during the power-up delay, with `cfg_bor_en`=1, returns to the brown-out hold at once. Timing then restarts from the next recovery.
- R7: `cfg_bor_en`=1 applies the power-up delay even when `cfg_pwrt_en`=0.
- R8: With `cfg_bor_en`=0, `supply_low` has no effect on `core_rst_n` or on the flags.
- R9: `mclr_n`=0 holds `core_rst_n` at 0 from the next clock edge while the timers keep running. If the timers have finished, `core_rst_n` rises at the first clock edge that samples `mclr_n`=1.
- R10: In `ST_RUN` with a crystal mode, a `wake_stb` pulse drops `core_rst_n` at the next edge and re-runs only the start-up count. In mode 3, `wake_stb` has no effect.
- R11: A one-cycle `sw_wr` loads `sw_wdata[0]` into `stat_por` and `sw_wdata[1]` into `stat_bor`. A brown-out clears `stat_bor` and holds it clear for the whole hold. Master-clear and wake leave both flags unchanged.
- R12: Loss of `pwr_good` drops `core_rst_n` without waiting for a clock edge. Every rise of `core_rst_n` happens on a `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-domain clock |
| osc_clk | input | 1 | Oscillator clock counted by the start-up timer |
| pwr_good | input | 1 | Power detected; low acts as asynchronous power-on reset |
| supply_low | input | 1 | Supply below brown-out threshold (clk domain) |
| rc_tick | input | 1 | One-cycle enable from the internal RC time base |
| mclr_n | input | 1 | External master clear, active low (clk domain) |
| wake_stb | input | 1 | One-cycle wake-from-sleep strobe |
| cfg_bor_en | input | 1 | Brown-out detection enable |
| cfg_pwrt_en | input | 1 | Power-up timer enable |
| cfg_osc_mode | input | 2 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 RC |
| sw_wr | input | 1 | Software write strobe for status flags |
| sw_wdata | input | 2 | Bit 0 power-on flag, bit 1 brown-out flag |
| core_rst_n | output | 1 | Core reset, active low |
| stat_por | output | 1 | Power-on status flag (0 after power-on reset) |
| stat_bor | output | 1 | Brown-out status flag (0 after brown-out reset) |

## Verification
The release delay is measured after power-up under random combinations of `cfg_pwrt_en`, `cfg_bor_en` and `cfg_osc_mode`. Each measured delay is compared with a window computed from the timer lengths. This separates the four cases: no delay, power-up delay only, start-up count only, and both chained. Directed supply patterns then tell a short dip apart from a filtered brown-out, check that the start-up count is left out after brown-out recovery, and check that a dip inside the power-up delay restarts it. Master-clear and wake strobes are applied after the timers expire, to show that release is immediate in one case and that only the start-up count repeats in the other. Flag readback after each event tells the causes apart.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_PWRT  = 3'd1,
        ST_OST   = 3'd2,
        ST_RUN   = 3'd3,
        ST_BROWN = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        OSC_LP = 2'd0,
        OSC_XT = 2'd1,
        OSC_HS = 2'd2,
        OSC_RC = 2'd3
    } osc_mode_e;

    localparam int FLAG_POR_BIT = 0;
    localparam int FLAG_BOR_BIT = 1;

    function automatic logic is_crystal(input logic [1:0] mode);
        return mode != 2'(OSC_RC);
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], d};
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/rstseq_tick_timer.sv
module rstseq_tick_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (!run)                   cnt_q <= '0;
        else if (tick && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LIMIT);

    // R2 R4
    done_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(run));
endmodule

// File: rtl/rstseq_ost.sv
module rstseq_ost #(
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic osc_clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(OST_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(OST_CYCLES);

    logic          run_osc;
    logic [CW-1:0] cnt_q;
    logic          done_osc_q;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
        .clk(osc_clk), .rst_n(rst_n), .d(run), .q(run_osc)
    );

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            done_osc_q <= 1'b0;
        end else begin
            if (!run_osc)            cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
            done_osc_q <= run_osc && (cnt_q == LIMIT);
        end
    end

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk(clk), .rst_n(rst_n), .d(done_osc_q), .q(done)
    );

    // R3
    ost_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (cnt_q == LIMIT) && run_osc |=> (cnt_q == LIMIT) || !run_osc);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int   PWRT_TICKS    = 72,
    parameter int   BOR_TICKS     = 4,
    parameter int   OST_CYCLES    = 1024,
    parameter int   SYNC_STAGES   = 2,
    parameter logic BOR_FLAG_INIT = 1'b1
) (
    input  logic       clk,
    input  logic       osc_clk,
    input  logic       pwr_good,
    input  logic       supply_low,
    input  logic       rc_tick,
    input  logic       mclr_n,
    input  logic       wake_stb,
    input  logic       cfg_bor_en,
    input  logic       cfg_pwrt_en,
    input  logic [1:0] cfg_osc_mode,
    input  logic       sw_wr,
    input  logic [1:0] sw_wdata,
    output logic       core_rst_n,
    output logic       stat_por,
    output logic       stat_bor
);
    seq_state_e state_q, nxt;
    logic need_pwrt, xtal;
    logic pwrt_run, pwrt_done;
    logic filt_run, bor_trip;
    logic ost_run, ost_done, ost_armed_q;
    logic por_path_q;

    assign need_pwrt = cfg_pwrt_en | cfg_bor_en;
    assign xtal      = is_crystal(cfg_osc_mode);
    assign pwrt_run  = (state_q == ST_PWRT);
    assign filt_run  = cfg_bor_en & supply_low;
    assign ost_run   = (state_q == ST_OST);

    rstseq_tick_timer #(.TICKS(PWRT_TICKS)) u_pwrt (
        .clk(clk), .rst_n(pwr_good), .run(pwrt_run), .tick(rc_tick), .done(pwrt_done)
    );

    rstseq_tick_timer #(.TICKS(BOR_TICKS)) u_bor_filt (
        .clk(clk), .rst_n(pwr_good), .run(filt_run), .tick(rc_tick), .done(bor_trip)
    );

    rstseq_ost #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ost (
        .clk(clk), .osc_clk(osc_clk), .rst_n(pwr_good), .run(ost_run), .done(ost_done)
    );

    // next-state decision
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_START: begin
                if (need_pwrt)  nxt = ST_PWRT;
                else if (xtal)  nxt = ST_OST;
                else            nxt = ST_RUN;
            end
            ST_PWRT: begin
                if (cfg_bor_en && supply_low) nxt = ST_BROWN;
                else if (pwrt_done)           nxt = (xtal && por_path_q) ? ST_OST : ST_RUN;
            end
            ST_OST: begin
                if (ost_armed_q && ost_done) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (wake_stb && xtal) nxt = ST_OST;
            end
            ST_BROWN: begin
                if (!supply_low) nxt = ST_PWRT;
            end
            default: nxt = ST_START;
        endcase
        if (bor_trip && state_q != ST_BROWN) nxt = ST_BROWN;
    end

    // state register and sequencing bookkeeping
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            state_q     <= ST_START;
            por_path_q  <= 1'b1;
            ost_armed_q <= 1'b0;
        end else begin
            state_q <= nxt;
            if (nxt == ST_BROWN) por_path_q <= 1'b0;
            if (state_q != ST_OST)  ost_armed_q <= 1'b0;
            else if (!ost_done)     ost_armed_q <= 1'b1;
        end
    end

    // outputs: core reset and status flags
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            core_rst_n <= 1'b0;
            stat_por   <= 1'b0;
            stat_bor   <= BOR_FLAG_INIT;
        end else begin
            core_rst_n <= (nxt == ST_RUN) && mclr_n;
            if (sw_wr) begin
                stat_por <= sw_wdata[FLAG_POR_BIT];
                stat_bor <= sw_wdata[FLAG_BOR_BIT];
            end
            if (nxt == ST_BROWN) stat_bor <= 1'b0;
        end
    end

    // R1
    por_set_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(stat_por) |-> $past(sw_wr) && $past(sw_wdata[FLAG_POR_BIT]));

    // R11
    bor_set_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(stat_bor) |-> $past(sw_wr));

    // R5
    brown_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (state_q == ST_BROWN) |-> !core_rst_n && !stat_bor);

    // R9 R12
    release_mclr_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(core_rst_n) |-> $past(mclr_n));

    // R2
    pwrt_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (state_q == ST_PWRT) |-> !core_rst_n);
endmodule

// File: tb/rstseq_top_tb.sv
`timescale 1ns/100ps
module rstseq_top_tb;
    localparam int PWRT_T   = 20;
    localparam int BOR_T    = 5;
    localparam int OST_C    = 16;
    localparam int TICK_DIV = 4;

    logic clk = 1'b0, osc_clk = 1'b0;
    logic pwr_good = 1'b0, supply_low = 1'b0, rc_tick = 1'b0, mclr_n = 1'b1, wake_stb = 1'b0;
    logic cfg_bor_en = 1'b0, cfg_pwrt_en = 1'b0, sw_wr = 1'b0;
    logic [1:0] cfg_osc_mode = 2'd3, sw_wdata = 2'd0;
    logic core_rst_n, stat_por, stat_bor;

    int total = 0, bad = 0;
    bit finished = 0;

    rstseq_top #(.PWRT_TICKS(PWRT_T), .BOR_TICKS(BOR_T), .OST_CYCLES(OST_C),
                 .SYNC_STAGES(2), .BOR_FLAG_INIT(1'b1)) u_dut (
        .clk(clk), .osc_clk(osc_clk), .pwr_good(pwr_good), .supply_low(supply_low),
        .rc_tick(rc_tick), .mclr_n(mclr_n), .wake_stb(wake_stb), .cfg_bor_en(cfg_bor_en),
        .cfg_pwrt_en(cfg_pwrt_en), .cfg_osc_mode(cfg_osc_mode), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .core_rst_n(core_rst_n), .stat_por(stat_por), .stat_bor(stat_bor)
    );

    initial forever #4 clk = ~clk;
    initial forever #5.5 osc_clk = ~osc_clk;

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % TICK_DIV;
            rc_tick = (div == 0);
        end
    end

    function automatic int win_lo(input bit pw, input bit ost);
        int v = 0;
        if (pw)  v += PWRT_T * TICK_DIV - 6;
        if (ost) v += (OST_C * 11) / 8;
        return v;
    endfunction

    function automatic int win_hi(input bit pw, input bit ost);
        int v = 6;
        if (pw)  v += PWRT_T * TICK_DIV + 6;
        if (ost) v += (OST_C * 11) / 8 + 16;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_release(input int limit, output int cyc);
        cyc = 0;
        while (!core_rst_n && cyc < limit) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic sw_write(input logic [1:0] v);
        @(negedge clk);
        sw_wr = 1'b1; sw_wdata = v;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic power_up(input bit bor, input bit pw, input logic [1:0] mode, output int cyc);
        @(negedge clk);
        pwr_good = 1'b0; supply_low = 1'b0; wake_stb = 1'b0; sw_wr = 1'b0;
        cycles(3);
        // R1 reset state while power is absent
        chk(core_rst_n == 1'b0, "R1 core reset during power loss", core_rst_n, 0);
        chk(stat_por == 1'b0, "R1 por flag during power loss", stat_por, 0);
        chk(stat_bor == 1'b1, "R1 bor flag init", stat_bor, 1);
        cfg_bor_en = bor; cfg_pwrt_en = pw; cfg_osc_mode = mode;
        @(negedge clk);
        pwr_good = 1'b1;
        wait_release(400, cyc);
    endtask

    initial begin
        int cyc;
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED1234);

        // random configuration sweep: R2 R3 R7 R1 R11
        for (int it = 0; it < 10; it++) begin
            bit b, p;
            logic [1:0] m, v;
            bit expect_pw, expect_ost;
            b = 1'($urandom); p = 1'($urandom); m = 2'($urandom);
            expect_pw  = p | b;
            expect_ost = (m != 2'd3);
            power_up(b, p, m, cyc);
            chk_win("R2/R3/R7 power-up release delay", cyc,
                    win_lo(expect_pw, expect_ost), win_hi(expect_pw, expect_ost));
            chk(stat_por == 1'b0, "R1 por flag after power-up", stat_por, 0);
            v = 2'($urandom);
            sw_write(v);
            chk({stat_bor, stat_por} == v, "R11 software flag load", {stat_bor, stat_por}, v);
        end

        // R7 directed: brown-out enable forces delay, XT mode
        power_up(1'b1, 1'b0, 2'd1, cyc);
        chk_win("R7 delay forced by brown-out enable", cyc, win_lo(1, 1), win_hi(1, 1));
        sw_write(2'b11);

        // R4 short dip ignored
        @(negedge clk); supply_low = 1'b1;
        cycles((BOR_T - 2) * TICK_DIV);
        chk(core_rst_n == 1'b1, "R4 short dip keeps core running", core_rst_n, 1);
        supply_low = 1'b0;
        cycles(4);
        chk(core_rst_n == 1'b1, "R4 after short dip", core_rst_n, 1);
        chk(stat_bor == 1'b1, "R4 bor flag kept on short dip", stat_bor, 1);

        // R5 long dip: brown-out, flag cause
        supply_low = 1'b1;
        cycles(40);
        chk(core_rst_n == 1'b0, "R5 long dip resets core", core_rst_n, 0);
        chk(stat_bor == 1'b0, "R11 bor flag cleared by brown-out", stat_bor, 0);
        chk(stat_por == 1'b1, "R11 por flag kept by brown-out", stat_por, 1);
        sw_write(2'b11);
        chk(stat_bor == 1'b0, "R11 bor flag held clear in hold", stat_bor, 0);
        cycles(40);
        chk(core_rst_n == 1'b0, "R5 held while supply low", core_rst_n, 0);
        supply_low = 1'b0;
        wait_release(400, cyc);
        chk_win("R5 recovery release without start-up count", cyc, win_lo(1, 0), win_hi(1, 0));

        // R6 dip during power-up delay restarts it
        @(negedge clk); supply_low = 1'b1;
        cycles(40);
        supply_low = 1'b0;
        cycles(30);
        supply_low = 1'b1;
        cycles(2);
        supply_low = 1'b0;
        wait_release(400, cyc);
        chk_win("R6 restart after dip inside delay", cyc, win_lo(1, 0), win_hi(1, 0));

        // R8 brown-out disabled ignores supply
        power_up(1'b0, 1'b1, 2'd3, cyc);
        sw_write(2'b11);
        @(negedge clk); supply_low = 1'b1;
        cycles(60);
        chk(core_rst_n == 1'b1, "R8 supply ignored when disabled", core_rst_n, 1);
        chk(stat_bor == 1'b1, "R8 bor flag untouched when disabled", stat_bor, 1);
        supply_low = 1'b0;

        // R9 master clear held through power-up, HS mode
        @(negedge clk); mclr_n = 1'b0;
        power_up(1'b0, 1'b1, 2'd2, cyc);
        cycles(200);
        chk(core_rst_n == 1'b0, "R9 held by master clear", core_rst_n, 0);
        sw_write(2'b01);
        @(negedge clk); mclr_n = 1'b1;
        @(negedge clk);
        chk(core_rst_n == 1'b1, "R9 immediate release after timers", core_rst_n, 1);
        mclr_n = 1'b0;
        @(negedge clk);
        chk(core_rst_n == 1'b0, "R9 master clear asserts next edge", core_rst_n, 0);
        mclr_n = 1'b1;
        @(negedge clk);
        chk(core_rst_n == 1'b1, "R9 release after pulse", core_rst_n, 1);
        chk(stat_por == 1'b1, "R11 por flag kept by master clear", stat_por, 1);

        // R10 wake strobe in crystal mode
        wake_stb = 1'b1;
        @(negedge clk);
        wake_stb = 1'b0;
        chk(core_rst_n == 1'b0, "R10 wake holds core", core_rst_n, 0);
        wait_release(400, cyc);
        chk_win("R10 wake reruns start-up count only", cyc - 1 + 1, win_lo(0, 1) - 1, win_hi(0, 1));
        chk(stat_por == 1'b1, "R11 por flag kept by wake", stat_por, 1);

        // R10 wake ignored in RC mode
        power_up(1'b0, 1'b1, 2'd3, cyc);
        @(negedge clk); wake_stb = 1'b1;
        @(negedge clk); wake_stb = 1'b0;
        cycles(10);
        chk(core_rst_n == 1'b1, "R10 wake ignored in RC mode", core_rst_n, 1);

        // R12 asynchronous assertion on power loss
        @(posedge clk);
        #2 pwr_good = 1'b0;
        #1;
        chk(core_rst_n == 1'b0, "R12 asynchronous reset on power loss", core_rst_n, 0);
        chk(stat_por == 1'b0, "R1 por flag cleared by power loss", stat_por, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule